// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets the cores of a small cluster of up to four cores interrupt one another. It keeps one pending flag for every ordered pair of cores (sender, target). Each core has one interrupt line, and that line is asserted whenever any flag aimed at that core is set. Any core can issue a command to raise an interrupt at another core. It can also ask whether an interrupt it raised earlier is still outstanding, read which senders are waiting on it, and acknowledge one sender.

Commands arrive one per cycle on a register-style interface. Each command carries a valid strobe, an opcode, the id of the issuing core and one argument. The argument is a target core id for raise and status commands, and a sender index for acknowledge. Query results come back on a registered readback port in the cycle after the query. When several cores interrupt the same target at once, the target sees one asserted line. Its source mask then has several bits set, and it clears the senders one at a time.

Top module: `ipi_hub`

## Requirements
- R1: A raise command (opcode 0) whose argument equals the issuing core changes no flag and asserts no line.
- R2: A raise command from core s with argument t (s different from t) sets the (s, t) flag, and irq_out[t] is high from the second clock edge after the command.
- R3: A status command (opcode 1) from core s with argument t returns 1 on rd_data in the cycle after the command if the (s, t) flag is set, and 0 otherwise.
- R4: A source command (opcode 2) from core c returns a mask in the cycle after the command, with bit s set exactly when the (s, c) flag is set. Bit c is always 0.
- R5: When flags from several senders are set toward one target, that target's single line is asserted and its source mask shows every one of those senders.
- R6: An acknowledge command (opcode 3) from core c with argument s clears only the (s, c) flag. All other flags are unchanged.
- R7: irq_out[t] stays high while any flag toward t is set. It goes low one cycle after the last such flag clears.
- R8: Raising a pair that is already pending leaves it pending, and a single acknowledge clears it.
- R9: rd_data holds its value on every cycle that carries no status or source command.
- R10: A synchronous active-low reset clears every flag, every line and rd_data.
- R11: When cmd_valid is low the command fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Opcode: 0 raise, 1 status, 2 source, 3 acknowledge |
| cmd_core | input | 2 | Id of the issuing core |
| cmd_arg | input | 2 | Target core id (raise, status) or sender index (acknowledge) |
| rd_data | output | 4 | Registered readback for status and source commands |
| irq_out | output | 4 | One interrupt line per core |

## Verification
The assertions assume that reset is held low for at least one clock edge before the first command, and that cmd_core and cmd_arg are valid core ids whenever cmd_valid is high. The bench holds reset for several cycles and only ever drives ids in the range 0 to 3. It sweeps every ordered pair of cores, including each core paired with itself. It then builds and unwinds a merged interrupt at one target, issuing the acknowledges one at a time.

// File: rtl/ipi_hub_pkg.sv
// Package: opcodes shared by the interrupt hub modules.
package ipi_hub_pkg;
    typedef enum logic [1:0] {
        OP_RAISE = 2'd0,
        OP_PEEK  = 2'd1,
        OP_WHO   = 2'd2,
        OP_ACK   = 2'd3
    } ipi_op_e;
endpackage

// File: rtl/ipi_hub_dec.sv
// Command decoder: turns one command into per-pair set and clear strobes
// plus query strobes. Assumes core ids below N. Self-raise strobes are
// never generated.
module ipi_hub_dec
    import ipi_hub_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           cmd_valid,
    input  ipi_op_e        cmd_op,
    input  logic [IDW-1:0] cmd_core,
    input  logic [IDW-1:0] cmd_arg,
    output logic [N*N-1:0] set_m,
    output logic [N*N-1:0] clr_m,
    output logic           peek_q,
    output logic           who_q
);
    // Query strobes
    assign peek_q = cmd_valid && (cmd_op == OP_PEEK);
    assign who_q  = cmd_valid && (cmd_op == OP_WHO);

    for (genvar s = 0; s < N; s++) begin : g_snd
        for (genvar t = 0; t < N; t++) begin : g_tgt
            if (s == t) begin : g_self
                // A core never raises at itself
                assign set_m[s*N+t] = 1'b0;
            end else begin : g_pair
                // Raise by sender s toward target t
                assign set_m[s*N+t] = cmd_valid && (cmd_op == OP_RAISE) &&
                                      (cmd_core == IDW'(s)) && (cmd_arg == IDW'(t));
            end
            // Ack issued by target t naming sender s
            assign clr_m[s*N+t] = cmd_valid && (cmd_op == OP_ACK) &&
                                  (cmd_core == IDW'(t)) && (cmd_arg == IDW'(s));
        end
    end
endmodule

// File: rtl/ipi_hub_pend.sv
// Pending matrix: one flag per (sender, target) pair, index s*N+t, and one
// registered interrupt line per target. Assumes set and clear of a pair
// never arrive in the same cycle.
module ipi_hub_pend #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*N-1:0] set_m,
    input  logic [N*N-1:0] clr_m,
    output logic [N*N-1:0] flags,
    output logic [N-1:0]   irq_q
);
    logic [N-1:0] col_any;

    // Flag storage: set wins nothing over clear, both never coincide
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags | set_m) & ~clr_m;
    end

    for (genvar t = 0; t < N; t++) begin : g_col
        // Any pending sender toward target t
        always_comb begin
            col_any[t] = 1'b0;
            for (int s = 0; s < N; s++) col_any[t] = col_any[t] | flags[s*N+t];
        end

        // Registered line toward target t
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[t] <= 1'b0;
            else        irq_q[t] <= col_any[t];
        end

        p_line_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
            col_any[t] |=> irq_q[t]);
        p_line_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !col_any[t] |=> !irq_q[t]);
        p_no_self_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !flags[t*N+t]);
    end

    for (genvar k = 0; k < N*N; k++) begin : g_cell
        p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_m[k] |=> flags[k]);
        p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clr_m[k] |=> !flags[k]);
        p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_m[k] && !clr_m[k]) |=> $stable(flags[k]));
    end

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && irq_q == '0));
endmodule

// File: rtl/ipi_hub_rdbk.sv
// Readback register: captures a status bit or a source mask on a query and
// holds it otherwise. Assumes core ids below N.
module ipi_hub_rdbk #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           peek_q,
    input  logic           who_q,
    input  logic [IDW-1:0] cmd_core,
    input  logic [IDW-1:0] cmd_arg,
    input  logic [N*N-1:0] flags,
    output logic [N-1:0]   rd_data
);
    localparam int FW = $clog2(N*N);

    logic [FW-1:0] pair_idx;
    logic [N-1:0]  who_vec;

    // Flat index of the (issuer, argument) pair
    assign pair_idx = FW'(cmd_core) * FW'(N) + FW'(cmd_arg);

    // Senders pending toward the issuer
    always_comb begin
        for (int s = 0; s < N; s++) who_vec[s] = flags[FW'(s) * FW'(N) + FW'(cmd_core)];
    end

    // Capture on query, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (peek_q) rd_data <= N'(flags[pair_idx]);
        else if (who_q)  rd_data <= who_vec;
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(peek_q || who_q) |=> $stable(rd_data));
    p_own_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        who_q |=> !rd_data[$past(cmd_core)]);
    p_peek_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        peek_q |=> (rd_data[N-1:1] == '0));
endmodule

// File: rtl/ipi_hub.sv
// Inter-processor interrupt hub top: decoder, pending matrix and readback.
// Assumes one command per cycle and core ids below N.
module ipi_hub
    import ipi_hub_pkg::*;
#(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [IDW-1:0] cmd_core,
    input  logic [IDW-1:0] cmd_arg,
    output logic [N-1:0]   rd_data,
    output logic [N-1:0]   irq_out
);
    logic [N*N-1:0] set_m, clr_m, flags;
    logic           peek_q, who_q;

    ipi_hub_dec #(.N(N), .IDW(IDW)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (ipi_op_e'(cmd_op)),
        .cmd_core  (cmd_core),
        .cmd_arg   (cmd_arg),
        .set_m     (set_m),
        .clr_m     (clr_m),
        .peek_q    (peek_q),
        .who_q     (who_q)
    );

    ipi_hub_pend #(.N(N)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_m (set_m),
        .clr_m (clr_m),
        .flags (flags),
        .irq_q (irq_out)
    );

    ipi_hub_rdbk #(.N(N), .IDW(IDW)) u_rdbk (
        .clk      (clk),
        .rst_n    (rst_n),
        .peek_q   (peek_q),
        .who_q    (who_q),
        .cmd_core (cmd_core),
        .cmd_arg  (cmd_arg),
        .flags    (flags),
        .rd_data  (rd_data)
    );

    p_invalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(flags));
    p_self_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0 && cmd_core == cmd_arg) |=> $stable(flags));
endmodule

// File: tb/test_ipi_hub.sv
module test_ipi_hub;
    localparam int N = 4;
    localparam int IDW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [IDW-1:0] cmd_core = '0, cmd_arg = '0;
    wire  [N-1:0] rd_data, irq_out;

    int checks = 0, errors = 0;
    bit mp [N][N];
    bit done = 0;

    ipi_hub i_ipi_hub (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
                       .cmd_core(cmd_core), .cmd_arg(cmd_arg), .rd_data(rd_data),
                       .irq_out(irq_out));

    always #5 clk = ~clk;

    task automatic chk(input logic [N-1:0] got, input logic [N-1:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_irq();
        logic [N-1:0] r = '0;
        for (int t = 0; t < N; t++)
            for (int s = 0; s < N; s++) if (mp[s][t]) r[t] = 1'b1;
        return r;
    endfunction

    function automatic logic [N-1:0] exp_who(input int c);
        logic [N-1:0] r = '0;
        for (int s = 0; s < N; s++) r[s] = mp[s][c];
        return r;
    endfunction

    // Issue one command; returns at the negedge after its capturing edge
    task automatic cmd(input int op, input int c, input int a, input bit v = 1'b1);
        @(negedge clk);
        cmd_valid = v; cmd_op = 2'(op); cmd_core = IDW'(c); cmd_arg = IDW'(a);
        if (v && op == 0 && c != a) mp[c][a] = 1'b1;
        if (v && op == 3) mp[a][c] = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] held;
        repeat (3) @(negedge clk);
        chk(irq_out, '0, "R10 lines after reset");
        chk(rd_data, '0, "R10 readback after reset");
        rst_n = 1'b1;

        // Sweep all ordered pairs, self pairs included
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                cmd(0, s, t);
                settle();
                chk(irq_out, exp_irq(), (s == t) ? "R1 self raise" : "R2 raise line");
                cmd(1, s, t);
                chk(rd_data, N'(mp[s][t]), "R3 status of raised pair");
                cmd(1, t, s);
                chk(rd_data, N'(mp[t][s]), "R3 status of reverse pair");
                cmd(2, t, 0);
                chk(rd_data, exp_who(t), "R4 source mask");
                cmd(3, t, s);
                settle();
                chk(irq_out, '0, "R7 line drops after ack");
            end
        end

        // Coalescing at core 0
        cmd(0, 1, 0); cmd(0, 2, 0); cmd(0, 3, 0);
        settle();
        chk(irq_out, 4'b0001, "R5 merged line");
        cmd(2, 0, 0);
        chk(rd_data, 4'b1110, "R5 merged mask");
        cmd(0, 2, 0);
        cmd(3, 0, 2);
        cmd(2, 0, 0);
        chk(rd_data, 4'b1010, "R8 one ack clears repeated raise");
        settle();
        chk(irq_out, 4'b0001, "R7 line held with senders left");
        cmd(3, 0, 1);
        cmd(3, 0, 3);
        chk(irq_out, 4'b0001, "R7 line one cycle after last ack");
        settle();
        chk(irq_out, 4'b0000, "R7 line low after lag");

        // Ack only touches its own pair
        cmd(0, 1, 2); cmd(0, 3, 0);
        cmd(3, 0, 1);
        cmd(1, 1, 2);
        chk(rd_data, 4'b0001, "R6 other pair kept (1,2)");
        cmd(1, 3, 0);
        chk(rd_data, 4'b0001, "R6 other pair kept (3,0)");
        cmd(3, 2, 1); cmd(3, 0, 3);
        settle();
        chk(irq_out, exp_irq(), "R6 lines after cleanup");

        // Readback holds without queries
        cmd(2, 2, 0);
        held = rd_data;
        cmd(0, 0, 2);
        cmd(3, 2, 0);
        settle();
        chk(rd_data, held, "R9 readback held");

        // Invalid strobe ignored
        cmd(0, 0, 1, 1'b0);
        settle();
        chk(irq_out, '0, "R11 no line from invalid command");
        cmd(1, 0, 1);
        chk(rd_data, '0, "R11 no flag from invalid command");

        // Reset in the middle of activity
        cmd(0, 2, 3); cmd(0, 0, 1);
        settle();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        for (int s = 0; s < N; s++) for (int t = 0; t < N; t++) mp[s][t] = 1'b0;
        chk(irq_out, '0, "R10 lines after mid reset");
        chk(rd_data, '0, "R10 readback after mid reset");
        cmd(1, 2, 3);
        chk(rd_data, '0, "R10 flag cleared by reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule